// File: doc/BRIEF.md
# Single-Port RAM with Lane Write Masks and Selectable Read-During-Write Policy

This block is one synchronous storage port: a single address both reads and writes one word-organised array, and read data comes out of a register one clock after the access. A clock enable gates the whole port. Writes are masked in lanes of `BYTE` bits. A build parameter picks how the lane mask arrives. In combined style the write-enable bus has one bit per lane. In split style there is one master write enable and a separate lane-enable bus.

A 3-bit runtime input, `rdwrMode`, decides what the read register captures when the same cycle also writes. The choices are: hold the previous output, show the stored word from before the write, show the merged word after the write, or leave some bits unspecified. In one undefined variant the written bits are unspecified. In the other, the unwritten bits are unspecified and the written bits carry the new data. Array contents start unspecified unless an initial word is supplied by parameter.

Top module: `bytewise_rw_ram`

## Requirements
- R1: Lane g covers data bits [g*BYTE +: BYTE]. When BYTE is at least DATA_W, there is one lane and its enable covers the whole word. DATA_W must be a multiple of BYTE whenever BYTE is smaller.
- R2: In combined style (SEPARATE_BE=0), `wrEn` has one bit per lane. Lane g is written at a rising edge when `ce` and `wrEn[g]` are both 1. `byteEn` has no effect in this style.
- R3: In split style (SEPARATE_BE=1), `wrEn` is one bit. Lane g is written only when `ce`, `wrEn[0]` and `byteEn[g]` are all 1. With `wrEn[0]` at 0, `byteEn` changes nothing.
- R4: While `ce` is 0, neither the array nor `rdData` changes.
- R5: A cycle with `ce` at 1 and no lane written loads `rdData`, one clock later, with the word stored at `addr`, whatever the mode.
- R6: `rdwrMode` codes are: 0 undefined, 1 hold, 2 old, 3 new, 4 new-only. Codes 5 to 7 act as code 0.
- R7: Hold (code 1): when any lane is written, `rdData` keeps its previous value.
- R8: Old (code 2): a write cycle returns the word as stored before the write.
- R9: New (code 3): a write cycle returns the written data on enabled lanes and the stored data on the other lanes.
- R10: Undefined (code 0): bits outside the enabled lanes return stored data. Bits inside the enabled lanes are unspecified.
- R11: New-only (code 4): bits inside the enabled lanes return the written data. All other bits are unspecified.
- R12: With INIT_EN=1, every word holds INIT_WORD before the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Clock enable for reads and writes |
| rdwrMode | input | 3 | Read-during-write policy code |
| addr | input | ADDR_W | Shared read/write word address |
| wrData | input | DATA_W | Write data |
| wrEn | input | SEPARATE_BE ? 1 : lanes | Write enable (per lane, or master) |
| byteEn | input | lanes | Lane enables, split style only |
| rdData | output | DATA_W | Registered read data |

## Verification
On every cycle, the embedded properties check four things. The read register freezes under a low clock enable and under hold-mode writes. The old and new policies return the pre-write word and the post-write word. An unwritten location keeps its content, and a clear master enable in split style blocks all writes. Only the bench scenarios can show the rest: the exact lane-to-bit mapping, the initial contents, the treatment of mode codes 5 to 7, and the lane-level content of the undefined and new-only results. The bench compares these against a per-lane reference array, for each style and for a single-lane width, with unspecified bits masked.

// File: rtl/bwram_pkg.sv
package bwram_pkg;

  typedef enum logic [2:0] {
    MODE_UNDEF   = 3'd0,
    MODE_HOLD    = 3'd1,
    MODE_OLD     = 3'd2,
    MODE_NEW     = 3'd3,
    MODE_NEWONLY = 3'd4
  } rdwrMode_e;

  typedef enum logic [1:0] {
    SRC_STORED,
    SRC_MERGED,
    SRC_XWRITTEN,
    SRC_XUNWRITTEN
  } rdSrc_e;

  typedef struct packed {
    logic   doWrite;
    logic   doRead;
    rdSrc_e rdSrc;
  } portStrobe_t;

  function automatic int laneCount(int dataW, int byteW);
    return (byteW >= dataW) ? 1 : dataW / byteW;
  endfunction

  function automatic int laneWidth(int dataW, int byteW);
    return (byteW >= dataW) ? dataW : byteW;
  endfunction

endpackage

// File: rtl/bwram_ctrl.sv
module bwram_ctrl
  import bwram_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SEPARATE_BE = 0,
  parameter int NLANES      = 4,
  parameter int LANE_W      = 8,
  parameter int WE_W        = 4
) (
  input  logic              ce,
  input  logic [2:0]        rdwrMode,
  input  logic [WE_W-1:0]   wrEn,
  input  logic [NLANES-1:0] byteEn,
  output portStrobe_t       strobe,
  output logic [DATA_W-1:0] bitMask
);

  logic [NLANES-1:0] laneEn;
  logic              anyWrite;
  rdwrMode_e         modeSel;

  // Lane enables from either encoding style; ce gates both.
  generate
    if (SEPARATE_BE != 0) begin : g_split
      assign laneEn = (ce && wrEn[0]) ? byteEn : '0;
    end else begin : g_combined
      logic unusedByteEn;
      assign unusedByteEn = ^byteEn;
      assign laneEn = ce ? wrEn : '0;
    end
  endgenerate

  // Expand each lane enable over its data bits.
  for (genvar g = 0; g < NLANES; g++) begin : g_expand
    assign bitMask[g*LANE_W +: LANE_W] = {LANE_W{laneEn[g]}};
  end

  assign anyWrite = |laneEn;
  assign modeSel  = (rdwrMode > 3'd4) ? MODE_UNDEF : rdwrMode_e'(rdwrMode);

  always_comb begin
    strobe.doWrite = anyWrite;
    strobe.doRead  = ce && !(anyWrite && modeSel == MODE_HOLD);
    if (!anyWrite) begin
      strobe.rdSrc = SRC_STORED;
    end else begin
      unique case (modeSel)
        MODE_OLD:     strobe.rdSrc = SRC_STORED;
        MODE_NEW:     strobe.rdSrc = SRC_MERGED;
        MODE_NEWONLY: strobe.rdSrc = SRC_XUNWRITTEN;
        MODE_HOLD:    strobe.rdSrc = SRC_STORED;
        default:      strobe.rdSrc = SRC_XWRITTEN;
      endcase
    end
  end

endmodule

// File: rtl/bwram_datapath.sv
module bwram_datapath
  import bwram_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 32,
  parameter int                DEPTH     = 16,
  parameter int                INIT_EN   = 0,
  parameter logic [DATA_W-1:0] INIT_WORD = '0
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] bitMask,
  input  portStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] storedWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] rdQ;
  logic              pastValid = 1'b0;

  generate
    if (INIT_EN != 0) begin : g_init
      initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = INIT_WORD;
      end
    end
  endgenerate

  assign storedWord = mem[addr];
  assign mergedWord = (wrData & bitMask) | (storedWord & ~bitMask);

  always_comb begin
    unique case (strobe.rdSrc)
      SRC_STORED:     rdNext = storedWord;
      SRC_MERGED:     rdNext = mergedWord;
      SRC_XWRITTEN:   rdNext = (storedWord & ~bitMask) | (bitMask & {DATA_W{1'bx}});
      SRC_XUNWRITTEN: rdNext = (wrData & bitMask) | (~bitMask & {DATA_W{1'bx}});
      default:        rdNext = storedWord;
    endcase
  end

  always @(posedge clk) begin
    if (strobe.doWrite) mem[addr] <= mergedWord;
  end

  always_ff @(posedge clk) begin
    if (strobe.doRead) rdQ <= rdNext;
  end

  always_ff @(posedge clk) pastValid <= 1'b1;

  assign rdData = rdQ;

  // R8 (also R5): a stored-word read returns the pre-edge content.
  assert_old_word_R8: assert property (@(posedge clk) disable iff (!pastValid)
    (strobe.doRead && strobe.rdSrc == SRC_STORED) |=> (rdQ === $past(storedWord)));

  // R9: the transparent read equals what the array holds after the write.
  assert_transparent_R9: assert property (@(posedge clk) disable iff (!pastValid)
    (strobe.doRead && strobe.rdSrc == SRC_MERGED) |=> (rdQ === mem[$past(addr)]));

  // R4: without a write strobe the addressed word keeps its content.
  assert_no_write_keeps_R4: assert property (@(posedge clk) disable iff (!pastValid)
    !strobe.doWrite |=> (mem[$past(addr)] === $past(storedWord)));

endmodule

// File: rtl/bytewise_rw_ram.sv
module bytewise_rw_ram
  import bwram_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 32,
  parameter int                BYTE        = 8,
  parameter int                SEPARATE_BE = 0,
  parameter int                INIT_EN     = 0,
  parameter logic [DATA_W-1:0] INIT_WORD   = '0,
  localparam int               NLANES      = laneCount(DATA_W, BYTE),
  localparam int               LANE_W      = laneWidth(DATA_W, BYTE),
  localparam int               WE_W        = (SEPARATE_BE != 0) ? 1 : NLANES,
  localparam int               DEPTH       = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              ce,
  input  logic [2:0]        rdwrMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [WE_W-1:0]   wrEn,
  input  logic [NLANES-1:0] byteEn,
  output logic [DATA_W-1:0] rdData
);

  generate
    if (BYTE < DATA_W && (DATA_W % BYTE) != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of BYTE");
    end
  endgenerate

  portStrobe_t       strobe;
  logic [DATA_W-1:0] bitMask;
  logic              portWrite;
  logic              pastValid = 1'b0;

  bwram_ctrl #(
    .DATA_W(DATA_W), .SEPARATE_BE(SEPARATE_BE),
    .NLANES(NLANES), .LANE_W(LANE_W), .WE_W(WE_W)
  ) ctrl_i (
    .ce(ce), .rdwrMode(rdwrMode), .wrEn(wrEn), .byteEn(byteEn),
    .strobe(strobe), .bitMask(bitMask)
  );

  bwram_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .INIT_EN(INIT_EN), .INIT_WORD(INIT_WORD)
  ) dp_i (
    .clk(clk), .addr(addr), .wrData(wrData), .bitMask(bitMask),
    .strobe(strobe), .rdData(rdData)
  );

  generate
    if (SEPARATE_BE != 0) begin : g_pw_split
      assign portWrite = wrEn[0] && (|byteEn);
    end else begin : g_pw_comb
      assign portWrite = |wrEn;
    end
  endgenerate

  always_ff @(posedge clk) pastValid <= 1'b1;

  // R4: a low clock enable freezes the read register.
  assert_ce_freeze_R4: assert property (@(posedge clk) disable iff (!pastValid)
    !ce |=> $stable(rdData));

  // R7: hold policy keeps the output across a write.
  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!pastValid)
    (ce && rdwrMode == 3'd1 && portWrite) |=> $stable(rdData));

  // R3: in split style a clear master enable suppresses every lane.
  assert_split_gate_R3: assert property (@(posedge clk) disable iff (!pastValid)
    (SEPARATE_BE != 0 && !wrEn[0]) |-> !strobe.doWrite);

endmodule

// File: tb/bytewise_rw_ram_tb_top.sv
module bytewise_rw_ram_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NW = 8;
  localparam logic [DW-1:0] INITW = 16'hA5C3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          ce = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic [1:0]    weC = '0;
  logic          weS = 1'b0;
  logic [1:0]    beS = '0;
  logic          weW = 1'b0;
  logic          beW = 1'b1;
  logic [DW-1:0] rdC, rdS, rdW;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [DW-1:0] memM   [3][NW];
  logic [DW-1:0] knownM [3][NW];
  logic [DW-1:0] expV [3];
  logic [DW-1:0] careV [3];

  bytewise_rw_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTE(8), .SEPARATE_BE(0),
                    .INIT_EN(1), .INIT_WORD(INITW)) dut_i (
    .clk(clk), .ce(ce), .rdwrMode(mode), .addr(addr), .wrData(wd),
    .wrEn(weC), .byteEn(beS), .rdData(rdC));

  bytewise_rw_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTE(8), .SEPARATE_BE(1),
                    .INIT_EN(1), .INIT_WORD(INITW)) dut_sep_i (
    .clk(clk), .ce(ce), .rdwrMode(mode), .addr(addr), .wrData(wd),
    .wrEn(weS), .byteEn(beS), .rdData(rdS));

  bytewise_rw_ram #(.ADDR_W(AW), .DATA_W(DW), .BYTE(32), .SEPARATE_BE(0),
                    .INIT_EN(0), .INIT_WORD('0)) dut_wide_i (
    .clk(clk), .ce(ce), .rdwrMode(mode), .addr(addr), .wrData(wd),
    .wrEn(weW), .byteEn(beW), .rdData(rdW));

  // Reference: read result first, then the array update.
  task automatic modelStep(int d, logic [DW-1:0] m);
    logic [DW-1:0] old, oldK, oldSrc, newSrc;
    int md;
    old  = memM[d][addr];
    oldK = knownM[d][addr];
    md   = (mode > 3'd4) ? 0 : int'(mode);
    if (ce && !(m != '0 && md == 1)) begin
      if (m == '0) begin
        oldSrc = '1; newSrc = '0;
      end else begin
        case (md)
          2:       begin oldSrc = '1; newSrc = '0; end
          3:       begin oldSrc = ~m; newSrc = m;  end
          4:       begin oldSrc = '0; newSrc = m;  end
          default: begin oldSrc = ~m; newSrc = '0; end
        endcase
      end
      expV[d]  = (old & oldSrc) | (wd & newSrc);
      careV[d] = (oldSrc & oldK) | newSrc;
    end
    memM[d][addr]   = (wd & m) | (old & ~m);
    knownM[d][addr] = oldK | m;
  endtask

  task automatic check(string req, string who, logic [DW-1:0] act,
                       logic [DW-1:0] exp, logic [DW-1:0] care);
    vectors++;
    if (((act ^ exp) & care) !== '0) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h (care mask %h)", req, who, act, exp, care);
    end
  endtask

  function automatic string reqFor(logic c, logic [2:0] md, logic wr);
    if (!c) return "R4";
    if (!wr) return "R5";
    if (md > 3'd4) return "R6";
    case (md)
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic cycle(logic c, logic [2:0] md, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic [1:0] wc, logic ws, logic [1:0] bs, logic ww,
                       string rqC, string rqS, string rqW);
    ce = c; mode = md; addr = a; wd = d; weC = wc; weS = ws; beS = bs; weW = ww;
    modelStep(0, c ? {{8{wc[1]}}, {8{wc[0]}}} : '0);
    modelStep(1, (c && ws) ? {{8{bs[1]}}, {8{bs[0]}}} : '0);
    modelStep(2, (c && ww) ? '1 : '0);
    @(posedge clk);
    @(negedge clk);
    check(rqC, "combined", rdC, expV[0], careV[0]);
    check(rqS, "split",    rdS, expV[1], careV[1]);
    check(rqW, "onelane",  rdW, expV[2], careV[2]);
  endtask

  initial begin
    for (int d = 0; d < 3; d++) begin
      expV[d] = '0; careV[d] = '0;
      for (int i = 0; i < NW; i++) begin
        memM[d][i]   = (d < 2) ? INITW : '0;
        knownM[d][i] = (d < 2) ? '1 : '0;
      end
    end
    @(negedge clk);
    @(negedge clk);

    // R12: initial contents, no writes.
    for (int a = 0; a < NW; a++)
      cycle(1'b1, 3'd2, AW'(a), '0, 2'b00, 1'b0, 2'b00, 1'b0, "R12", "R12", "R5");

    // R1: fill the single-lane instance through its whole-word enable.
    for (int a = 0; a < NW; a++)
      cycle(1'b1, 3'd2, AW'(a), 16'(a * 4111 + 7), 2'b00, 1'b0, 2'b00, 1'b1, "R5", "R5", "R1");

    // Sweep every mode code, address and lane pattern; each write is followed by a plain read.
    for (int md = 0; md < 8; md++) begin
      for (int a = 0; a < NW; a++) begin
        for (int k = 0; k < 5; k++) begin
          logic [DW-1:0] pat;
          logic [1:0]    wc, bs;
          logic          ws, ww;
          pat = 16'((md * 40 + a * 5 + k + 1) * 4951) ^ 16'h6C00;
          wc  = (k < 4) ? 2'(k) : 2'b00;
          bs  = (k < 4) ? 2'(k) : 2'b11;
          ws  = (k > 0 && k < 4);
          ww  = k[0];
          cycle(1'b1, 3'(md), AW'(a), pat, wc, ws, bs, ww,
                reqFor(1'b1, 3'(md), wc != 0),
                (k == 4) ? "R3" : reqFor(1'b1, 3'(md), ws && bs != 0),
                reqFor(1'b1, 3'(md), ww));
          cycle(1'b1, 3'(md), AW'(a), ~pat, 2'b00, 1'b0, 2'b11, 1'b0, "R2", "R3", "R1");
        end
      end
    end

    // R4: write attempts with the clock enable low, then read back.
    for (int a = 0; a < NW; a += 3) begin
      cycle(1'b0, 3'd3, AW'(a), 16'hFFFF, 2'b11, 1'b1, 2'b11, 1'b1, "R4", "R4", "R4");
      cycle(1'b0, 3'd2, AW'(a + 1), 16'h0000, 2'b00, 1'b0, 2'b00, 1'b0, "R4", "R4", "R4");
      cycle(1'b1, 3'd2, AW'(a), 16'h1234, 2'b00, 1'b0, 2'b00, 1'b0, "R4", "R4", "R4");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R5 watchdog: actual run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule